// File: doc/BRIEF.md
# Mixed-Aspect True Dual-Port RAM

This block is a synchronous RAM of 18,432 bits (16,384 data bits and 2,048 parity bits) that two ports share. Each port sets its own word shape at elaboration from six choices: 1, 2, 4, 8, 16 or 32 data bits per word. The depth is then 16,384 divided by the width. Ports of 8 bits or more also carry one parity bit per data byte. Ports narrower than a byte see only the data bits. One port can write narrow words while the other reads wide words over the same bits. The parity bits are stored and returned as written and are never checked.

Both ports run on a single clock. Each port has its own enable, write enable, address, write data and registered read data. A port word is packed with its parity bits above its data bits. The ports are plain pins with no handshake: every enabled cycle is accepted, and read data is always taken. Reading is read-first. An enabled port returns the contents from before the edge, including bits that either port writes in that same cycle. If both ports write the same bit in one cycle, the stored value is undefined.

Top module: `mdp_ram`

## Requirements
- R1: Parameter `DW_A` (and `DW_B`) is one of 1, 2, 4, 8, 16 or 32. The port word is `DW + DW/8` bits wide for widths of 8 or more, and `DW` bits wide otherwise. Data sits in bits `[DW-1:0]` and parity bit j sits in bit `DW+j`. The port depth is `16384/DW`.
- R2: Word k of a port with DW data bits holds shared data bits k*DW through k*DW+DW-1, with bit i of the word on shared bit k*DW+i. The same bits are therefore seen by both ports whatever their widths.
- R3: Parity bit j of word k on a port with P parity bits per word is shared parity bit k*P+j. A port of 1, 2 or 4 bits never changes any parity bit.
- R4: When a port has enable and write enable high at a rising clock edge, that word is stored. Read data is registered: it appears on the port's output after the edge that sampled the enable, and a read in the next cycle returns the new word.
- R5: An enabled port returns the contents from before the edge. This holds when the same port writes that word in the same cycle, and when the other port writes those bits in the same cycle.
- R6: While a port's enable is low, it writes nothing even if its write enable is high, and its output register keeps its value.
- R7: While `rst_n` is low, both output registers read zero. Reset leaves the stored contents untouched.
- R8: Both ports may write the same 32-bit row in one cycle. When their bits do not overlap, both writes are kept.
- R9: The two ports act independently in any cycle: both may read, both may write, or one may read while the other writes, at unrelated addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low reset of the output registers |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write enable |
| a_addr | input | log2(16384/DW_A) | Port A word address |
| a_din | input | DW_A + DW_A/8 (DW_A>=8) else DW_A | Port A write word, parity above data |
| a_dout | output | same as a_din | Port A registered read word |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write enable |
| b_addr | input | log2(16384/DW_B) | Port B word address |
| b_din | input | DW_B + DW_B/8 (DW_B>=8) else DW_B | Port B write word, parity above data |
| b_dout | output | same as b_din | Port B registered read word |

## Verification
Every result is due at a known edge. A read or a write sampled at one rising edge puts its word on the output register at that same edge, and a write becomes readable by either port in the following cycle. The bench drives inputs on the falling edge, lets one rising edge pass and compares both outputs at the next falling edge. It compares against a bit-level model that produces its read words from the state before the write. A disabled port is compared against its previous output, so the hold behaviour is checked in every idle cycle. Two instances with different width pairs cover the byte-parity shapes and the sub-byte shapes.

// File: rtl/mdp_ram_pkg.sv
package mdp_ram_pkg;

  localparam int DATA_BITS = 16384;
  localparam int ROW_W     = 32;
  localparam int ROW_P     = ROW_W / 8;
  localparam int ROWS      = DATA_BITS / ROW_W;
  localparam int ROW_AW    = $clog2(ROWS);

  function automatic int par_bits(input int dw);
    return (dw >= 8) ? dw / 8 : 0;
  endfunction

  function automatic int port_bits(input int dw);
    return dw + par_bits(dw);
  endfunction

  typedef struct packed {
    logic              wr;
    logic [ROW_AW-1:0] row;
    logic [ROW_W-1:0]  dmask;
    logic [ROW_W-1:0]  ddata;
    logic [ROW_P-1:0]  pmask;
    logic [ROW_P-1:0]  pdata;
  } row_req_t;

endpackage

// File: rtl/mdp_port.sv
module mdp_port
  import mdp_ram_pkg::*;
#(
  parameter int DW = 8,
  localparam int PW    = par_bits(DW),
  localparam int PORTW = port_bits(DW),
  localparam int AW    = $clog2(DATA_BITS / DW)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   we,
  input  logic [AW-1:0]          addr,
  input  logic [PORTW-1:0]       din,
  output logic [PORTW-1:0]       dout,
  output row_req_t               req,
  input  logic [ROW_W-1:0]       rd_d,
  input  logic [ROW_P-1:0]       rd_p
);

  localparam int LANES = ROW_W / DW;
  localparam int LB    = $clog2(LANES);

  logic [4:0]       lane;
  logic [4:0]       doff;
  logic [1:0]       poff;
  logic [DW-1:0]    rd_dsel;
  logic [PORTW-1:0] rd_word;

  generate
    if (LB == 0) begin : g_full_row
      assign req.row = addr;
      assign lane    = '0;
    end else begin : g_lane_row
      assign req.row = addr[AW-1:LB];
      assign lane    = 5'(addr[LB-1:0]);
    end
  endgenerate

  assign doff      = 5'(32'(lane) * DW);
  assign req.wr    = en & we;
  assign req.dmask = ROW_W'((64'd1 << DW) - 64'd1) << doff;
  assign req.ddata = ROW_W'(din[DW-1:0]) << doff;
  assign rd_dsel   = DW'(rd_d >> doff);

  generate
    if (PW > 0) begin : g_parity
      logic [PW-1:0] rd_psel;
      assign poff      = 2'(32'(lane) * PW);
      assign req.pmask = ROW_P'((32'd1 << PW) - 32'd1) << poff;
      assign req.pdata = ROW_P'(din[PORTW-1:DW]) << poff;
      assign rd_psel   = PW'(rd_p >> poff);
      assign rd_word   = {rd_psel, rd_dsel};
    end else begin : g_no_parity
      logic unused_parity;
      assign poff          = '0;
      assign req.pmask     = '0;
      assign req.pdata     = '0;
      assign unused_parity = ^{rd_p, poff};
      assign rd_word       = rd_dsel;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)  dout <= '0;
    else if (en) dout <= rd_word;
  end

  p_reset_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> dout == '0);

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(dout));

  p_dmask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && we) |-> $countones(req.dmask) == DW);

  p_pmask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && we) |-> $countones(req.pmask) == PW);

endmodule

// File: rtl/mdp_store.sv
module mdp_store
  import mdp_ram_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  row_req_t         req_a,
  input  row_req_t         req_b,
  output logic [ROW_W-1:0] rd_a_d,
  output logic [ROW_P-1:0] rd_a_p,
  output logic [ROW_W-1:0] rd_b_d,
  output logic [ROW_P-1:0] rd_b_p
);

  logic [ROW_W-1:0] mem_d [ROWS];
  logic [ROW_P-1:0] mem_p [ROWS];

  logic             same_row;
  logic [ROW_W-1:0] new_a_d, base_b_d, new_b_d;
  logic [ROW_P-1:0] new_a_p, base_b_p, new_b_p;

  assign rd_a_d = mem_d[req_a.row];
  assign rd_a_p = mem_p[req_a.row];
  assign rd_b_d = mem_d[req_b.row];
  assign rd_b_p = mem_p[req_b.row];

  assign same_row = req_a.wr && (req_a.row == req_b.row);

  assign new_a_d  = (rd_a_d & ~req_a.dmask) | (req_a.ddata & req_a.dmask);
  assign new_a_p  = (rd_a_p & ~req_a.pmask) | (req_a.pdata & req_a.pmask);
  assign base_b_d = same_row ? new_a_d : rd_b_d;
  assign base_b_p = same_row ? new_a_p : rd_b_p;
  assign new_b_d  = (base_b_d & ~req_b.dmask) | (req_b.ddata & req_b.dmask);
  assign new_b_p  = (base_b_p & ~req_b.pmask) | (req_b.pdata & req_b.pmask);

  always_ff @(posedge clk) begin
    if (req_a.wr) begin
      mem_d[req_a.row] <= new_a_d;
      mem_p[req_a.row] <= new_a_p;
    end
    if (req_b.wr) begin
      mem_d[req_b.row] <= new_b_d;
      mem_p[req_b.row] <= new_b_p;
    end
  end

  p_write_lands_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_a.wr && !(req_b.wr && req_b.row == req_a.row &&
       (|(req_b.dmask & req_a.dmask) || |(req_b.pmask & req_a.pmask))))
    |=> (((mem_d[$past(req_a.row)] ^ $past(req_a.ddata)) & $past(req_a.dmask)) == '0) &&
        (((mem_p[$past(req_a.row)] ^ $past(req_a.pdata)) & $past(req_a.pmask)) == '0));

  p_write_lands_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_b.wr
    |=> (((mem_d[$past(req_b.row)] ^ $past(req_b.ddata)) & $past(req_b.dmask)) == '0) &&
        (((mem_p[$past(req_b.row)] ^ $past(req_b.pdata)) & $past(req_b.pmask)) == '0));

  p_quiet_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_a.wr && !req_b.wr)
    |=> mem_d[$past(req_a.row)] == $past(rd_a_d) && mem_p[$past(req_a.row)] == $past(rd_a_p));

endmodule

// File: rtl/mdp_ram.sv
module mdp_ram
  import mdp_ram_pkg::*;
#(
  parameter int DW_A = 8,
  parameter int DW_B = 32,
  localparam int AW_A = $clog2(DATA_BITS / DW_A),
  localparam int AW_B = $clog2(DATA_BITS / DW_B),
  localparam int PB_A = port_bits(DW_A),
  localparam int PB_B = port_bits(DW_B)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            a_en,
  input  logic            a_we,
  input  logic [AW_A-1:0] a_addr,
  input  logic [PB_A-1:0] a_din,
  output logic [PB_A-1:0] a_dout,
  input  logic            b_en,
  input  logic            b_we,
  input  logic [AW_B-1:0] b_addr,
  input  logic [PB_B-1:0] b_din,
  output logic [PB_B-1:0] b_dout
);

  row_req_t         req_a, req_b;
  logic [ROW_W-1:0] rd_a_d, rd_b_d;
  logic [ROW_P-1:0] rd_a_p, rd_b_p;

  mdp_port #(.DW(DW_A)) u_port_a (
    .clk(clk), .rst_n(rst_n), .en(a_en), .we(a_we), .addr(a_addr),
    .din(a_din), .dout(a_dout), .req(req_a), .rd_d(rd_a_d), .rd_p(rd_a_p)
  );

  mdp_port #(.DW(DW_B)) u_port_b (
    .clk(clk), .rst_n(rst_n), .en(b_en), .we(b_we), .addr(b_addr),
    .din(b_din), .dout(b_dout), .req(req_b), .rd_d(rd_b_d), .rd_p(rd_b_p)
  );

  mdp_store u_store (
    .clk(clk), .rst_n(rst_n), .req_a(req_a), .req_b(req_b),
    .rd_a_d(rd_a_d), .rd_a_p(rd_a_p), .rd_b_d(rd_b_d), .rd_b_p(rd_b_p)
  );

endmodule

// File: tb/mdp_ram_bench.sv
module mdp_ram_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // instance 1: A = 8+1 bits x 2K, B = 32+4 bits x 512
  logic        a1_en = 0, a1_we = 0, b1_en = 0, b1_we = 0;
  logic [10:0] a1_addr = '0;
  logic [8:0]  a1_din = '0, a1_dout;
  logic [8:0]  b1_addr = '0;
  logic [35:0] b1_din = '0, b1_dout;
  // instance 2: A = 2 bits x 8K, B = 16+2 bits x 1K
  logic        a2_en = 0, a2_we = 0, b2_en = 0, b2_we = 0;
  logic [12:0] a2_addr = '0;
  logic [1:0]  a2_din = '0, a2_dout;
  logic [9:0]  b2_addr = '0;
  logic [17:0] b2_din = '0, b2_dout;

  mdp_ram #(.DW_A(8), .DW_B(32)) u_mdp_ram (
    .clk(clk), .rst_n(rst_n),
    .a_en(a1_en), .a_we(a1_we), .a_addr(a1_addr), .a_din(a1_din), .a_dout(a1_dout),
    .b_en(b1_en), .b_we(b1_we), .b_addr(b1_addr), .b_din(b1_din), .b_dout(b1_dout));

  mdp_ram #(.DW_A(2), .DW_B(16)) u_mdp_ram_nb (
    .clk(clk), .rst_n(rst_n),
    .a_en(a2_en), .a_we(a2_we), .a_addr(a2_addr), .a_din(a2_din), .a_dout(a2_dout),
    .b_en(b2_en), .b_we(b2_we), .b_addr(b2_addr), .b_din(b2_din), .b_dout(b2_dout));

  logic [16383:0] md1 = '0, md2 = '0;
  logic [2047:0]  mp1 = '0, mp2 = '0;
  logic [35:0]    ea1 = '0, eb1 = '0, ea2 = '0, eb2 = '0;

  function automatic logic [35:0] mget(input logic [16383:0] md, input logic [2047:0] mp,
                                       input int dw, input int pw, input int k);
    logic [35:0] r = '0;
    for (int i = 0; i < dw; i++) r[i] = md[k*dw+i];
    for (int j = 0; j < pw; j++) r[dw+j] = mp[k*pw+j];
    return r;
  endfunction

  function automatic logic [16383:0] dput(input logic [16383:0] md, input int dw,
                                          input int k, input logic [35:0] v);
    for (int i = 0; i < dw; i++) md[k*dw+i] = v[i];
    return md;
  endfunction

  function automatic logic [2047:0] pput(input logic [2047:0] mp, input int dw, input int pw,
                                         input int k, input logic [35:0] v);
    for (int j = 0; j < pw; j++) mp[k*pw+j] = v[dw+j];
    return mp;
  endfunction

  function automatic logic [35:0] pat(input int k, input int salt);
    return 36'((longint'(k) * 64'h9E3779B97) ^ (longint'(salt) * 64'h5A5A5A5A5));
  endfunction

  task automatic chk(input string tag, input logic [35:0] got, input logic [35:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One cycle on instance 1, starting and ending at a falling edge.
  task automatic tick1(input string tag, input logic aen, input logic awe, input int aad,
                       input logic [35:0] ad, input logic ben, input logic bwe,
                       input int bad, input logic [35:0] bd);
    a1_en = aen; a1_we = awe; a1_addr = 11'(aad); a1_din = 9'(ad);
    b1_en = ben; b1_we = bwe; b1_addr = 9'(bad); b1_din = bd;
    if (aen) ea1 = mget(md1, mp1, 8, 1, aad);
    if (ben) eb1 = mget(md1, mp1, 32, 4, bad);
    if (aen && awe) begin md1 = dput(md1, 8, aad, ad); mp1 = pput(mp1, 8, 1, aad, ad); end
    if (ben && bwe) begin md1 = dput(md1, 32, bad, bd); mp1 = pput(mp1, 32, 4, bad, bd); end
    @(posedge clk);
    @(negedge clk);
    a1_en = 0; a1_we = 0; b1_en = 0; b1_we = 0;
    chk({tag, " port A"}, 36'(a1_dout), ea1);
    chk({tag, " port B"}, b1_dout, eb1);
  endtask

  task automatic tick2(input string tag, input logic aen, input logic awe, input int aad,
                       input logic [35:0] ad, input logic ben, input logic bwe,
                       input int bad, input logic [35:0] bd);
    a2_en = aen; a2_we = awe; a2_addr = 13'(aad); a2_din = 2'(ad);
    b2_en = ben; b2_we = bwe; b2_addr = 10'(bad); b2_din = 18'(bd);
    if (aen) ea2 = mget(md2, mp2, 2, 0, aad);
    if (ben) eb2 = mget(md2, mp2, 16, 2, bad);
    if (aen && awe) md2 = dput(md2, 2, aad, ad);
    if (ben && bwe) begin md2 = dput(md2, 16, bad, bd); mp2 = pput(mp2, 16, 2, bad, bd); end
    @(posedge clk);
    @(negedge clk);
    a2_en = 0; a2_we = 0; b2_en = 0; b2_we = 0;
    chk({tag, " port A"}, 36'(a2_dout), ea2);
    chk({tag, " port B"}, 36'(b2_dout), eb2);
  endtask

  task automatic t_reset_r7;
    chk("R7 reset a1", 36'(a1_dout), '0);
    chk("R7 reset b1", b1_dout, '0);
    chk("R7 reset a2", 36'(a2_dout), '0);
    chk("R7 reset b2", 36'(b2_dout), '0);
  endtask

  task automatic t_fill_r4;
    for (int k = 0; k < 512; k++) tick1("R4 fill", 0, 0, 0, '0, 1, 1, k, pat(k, 1));
    for (int k = 0; k < 1024; k++) tick2("R4 fill", 0, 0, 0, '0, 1, 1, k, pat(k, 2));
    tick1("R4 readback", 0, 0, 0, '0, 1, 0, 7, '0);
    tick2("R4 readback", 0, 0, 0, '0, 1, 0, 1023, '0);
  endtask

  task automatic t_narrow_to_wide_r2;
    for (int k = 8; k < 12; k++) tick1("R2 R3 byte write", 1, 1, k, pat(k, 3), 0, 0, 0, '0);
    tick1("R2 R3 row read", 0, 0, 0, '0, 1, 0, 2, '0);
    tick1("R1 parity bit", 1, 1, 0, 36'h100, 0, 0, 0, '0);
    tick1("R1 parity bit", 0, 0, 0, '0, 1, 0, 0, '0);
    for (int k = 0; k < 16; k++) tick2("R2 pair write", 1, 1, k, 36'(k), 0, 0, 0, '0);
    tick2("R2 R3 halfword 0", 0, 0, 0, '0, 1, 0, 0, '0);
    tick2("R2 R3 halfword 1", 0, 0, 0, '0, 1, 0, 1, '0);
  endtask

  task automatic t_wide_to_narrow_r2;
    tick1("R2 last row write", 0, 0, 0, '0, 1, 1, 511, 36'hA_8765_4321);
    for (int k = 2044; k < 2048; k++) tick1("R2 last bytes", 1, 0, k, '0, 0, 0, 0, '0);
    tick2("R2 last half", 0, 0, 0, '0, 1, 1, 1023, 36'h2_BEEF);
    for (int k = 8184; k < 8192; k++) tick2("R2 last pairs", 1, 0, k, '0, 0, 0, 0, '0);
  endtask

  task automatic t_read_first_r5;
    tick1("R5 cross-port old", 1, 1, 20, 36'h1C3, 1, 0, 5, '0);
    tick1("R5 new visible", 1, 0, 20, '0, 1, 0, 5, '0);
    tick1("R5 same-port old", 1, 1, 21, 36'h05A, 0, 0, 0, '0);
    tick1("R5 wide write narrow read", 1, 0, 22, '0, 1, 1, 5, 36'h0_FACE_B00C);
    tick1("R5 after", 1, 0, 22, '0, 0, 0, 0, '0);
  endtask

  task automatic t_enable_r6;
    tick1("R6 disabled write", 0, 1, 20, 36'h0FF, 0, 1, 5, 36'hF_FFFF_FFFF);
    tick1("R6 idle hold", 0, 0, 0, '0, 0, 0, 0, '0);
    tick1("R6 contents kept", 1, 0, 20, '0, 1, 0, 5, '0);
    tick2("R6 disabled write", 0, 1, 3, 36'h3, 0, 1, 0, 36'h3FFFF);
    tick2("R6 contents kept", 1, 0, 3, '0, 1, 0, 0, '0);
  endtask

  task automatic t_narrow_parity_r3;
    tick2("R3 narrow write", 1, 1, 40, 36'h2, 0, 0, 0, '0);
    tick2("R3 parity untouched", 0, 0, 0, '0, 1, 0, 5, '0);
  endtask

  task automatic t_dual_write_r8;
    tick2("R8 same row", 1, 1, 32, 36'h1, 1, 1, 5, 36'h1_5A5A);
    tick2("R8 half 4", 1, 0, 32, '0, 1, 0, 4, '0);
    tick2("R8 half 5", 0, 0, 0, '0, 1, 0, 5, '0);
  endtask

  task automatic t_independent_r9;
    tick1("R9 two reads", 1, 0, 3, '0, 1, 0, 100, '0);
    tick1("R9 two writes", 1, 1, 400, 36'h133, 1, 1, 200, 36'h9_0F0F_0F0F);
    tick1("R9 check", 1, 0, 400, '0, 1, 0, 200, '0);
    tick1("R9 write vs read", 1, 0, 1601, '0, 1, 1, 17, 36'h3_1234_5678);
    tick1("R9 check", 1, 0, 69, '0, 1, 0, 400 / 4, '0);
  endtask

  task automatic t_reset_again_r7;
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    ea1 = '0; eb1 = '0; ea2 = '0; eb2 = '0;
    t_reset_r7();
    rst_n = 1'b1;
    tick1("R7 contents kept", 1, 0, 20, '0, 1, 0, 200, '0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset_r7();
    rst_n = 1'b1;
    t_fill_r4();
    t_narrow_to_wide_r2();
    t_wide_to_narrow_r2();
    t_read_first_r5();
    t_enable_r6();
    t_narrow_parity_r3();
    t_dual_write_r8();
    t_independent_r9();
    t_reset_again_r7();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

endmodule